// File: doc/BRIEF.md
# Timer Tick Reinjection Controller

This block sits between a periodic timer tick and an edge-triggered interrupt line. The interrupt consumer is slow to acknowledge. Ticks that arrive while an earlier interrupt is still unacknowledged are not lost. They are counted as backlog, and they are released later, one interrupt for each acknowledge. The output is a single-cycle interrupt pulse.

A reinject enable selects between two behaviours. With the enable high, deliveries are gated by an acknowledge flag and the backlog counter. With the enable low, every tick is forwarded as a pulse without gating. The backlog state goes back to empty when the timer is reprogrammed, when the interrupt line is unmasked, or when reinjection is switched on. On reprogramming, the block also latches the requested tick interval and raises it to a configured floor if the request is below that floor.

Top module: `tick_reinject`

## Requirements
- R1: After reset, irqOut is 0 and effPeriod equals MIN_PERIOD. The backlog is empty and the acknowledge flag is set, so the first enabled tick after reset is delivered.
- R2: With reinjectEn high and the acknowledge flag set, a tick raises irqOut for exactly the one cycle after the tick cycle. It adds one to the backlog and clears the flag.
- R3: With reinjectEn high and the acknowledge flag clear, a tick produces no pulse but still adds one to the backlog.
- R4: With reinjectEn high, an acknowledge sets the flag and then decrements a non-zero backlog. If the decremented backlog is still above zero, a pulse follows in the next cycle and the flag clears again. An acknowledge with an empty backlog produces no pulse.
- R5: When a tick and an acknowledge share a cycle, the acknowledge is applied first and the tick second. At most one pulse results.
- R6: The backlog counter (CNT_W bits) saturates at 2^CNT_W-1 instead of wrapping.
- R7: A reprogram strobe, an unmask event or a rising edge of reinjectEn empties the backlog and sets the flag. A tick or acknowledge in that same cycle is discarded and gives no pulse.
- R8: With reinjectEn low, every tick gives a pulse in the next cycle. An acknowledge produces no pulse and no backlog change.
- R9: On a reprogram strobe, effPeriod takes reqPeriod, or MIN_PERIOD when reqPeriod is smaller. The new value is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Timer expiry pulse |
| ackIn | input | 1 | Interrupt acknowledge pulse |
| unmaskIn | input | 1 | Interrupt line unmask event |
| reinjectEn | input | 1 | Enables backlog counting and acknowledge gating |
| reprogramIn | input | 1 | Timer reprogram strobe |
| reqPeriod | input | PERIOD_W | Requested tick interval, sampled on reprogramIn |
| irqOut | output | 1 | Single-cycle interrupt pulse |
| effPeriod | output | PERIOD_W | Clamped tick interval |

## Verification
The backlog count has no port, so the hardest state to reach is a saturated backlog that the bench can still check. The bench reaches it by letting one tick take the flag and then sending far more ticks than the counter can hold. It then counts the pulses released by a long run of acknowledges: that count equals the saturated value minus one, while a wrapping counter would release only a handful. A second hard case is an acknowledge that arrives while reinjection is off and leaves the flag clear. The bench shows that re-enabling reinjection restores the flag, by checking that the next tick is delivered.

// File: rtl/tick_reinject_pkg.sv
package tick_reinject_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrState;  // empty backlog, set ack flag
    logic ackSet;    // set ack flag
    logic decPend;   // backlog minus one (applied first)
    logic incPend;   // backlog plus one, saturating (applied second)
    logic deliver;   // fire interrupt pulse, clear ack flag
  } ctrlStrobe_t;
endpackage

// File: rtl/tick_reinject_ctrl.sv
module tick_reinject_ctrl
  import tick_reinject_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic        ackIn,
  input  logic        unmaskIn,
  input  logic        reinjectEn,
  input  logic        reprogramIn,
  input  logic        pendNonZero,
  input  logic        pendAboveOne,
  input  logic        ackFlag,
  output ctrlStrobe_t strobe
);
  logic enPrev;
  logic enRise;
  logic clrEvent;
  logic ackRequest;
  logic flagAfterAck;

  always_ff @(posedge clk) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= reinjectEn;
  end

  always_comb begin
    enRise       = reinjectEn & ~enPrev;
    clrEvent     = reprogramIn | unmaskIn | enRise;
    ackRequest   = 1'b0;
    flagAfterAck = ackFlag;
    strobe       = '0;
    strobe.clrState = clrEvent;
    if (!reinjectEn) begin
      // direct forwarding, no gating
      strobe.deliver = tickIn;
    end else if (!clrEvent) begin
      // acknowledge first, then tick
      strobe.ackSet  = ackIn;
      strobe.decPend = ackIn & pendNonZero;
      ackRequest     = ackIn & pendAboveOne;
      flagAfterAck   = ackFlag | ackIn;
      strobe.incPend = tickIn;
      strobe.deliver = (ackRequest | tickIn) & flagAfterAck;
    end
  end
endmodule

// File: rtl/tick_reinject_dp.sv
module tick_reinject_dp
  import tick_reinject_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int PERIOD_W   = 16,
  parameter int MIN_PERIOD = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic                reprogramIn,
  input  logic [PERIOD_W-1:0] reqPeriod,
  output logic                pendNonZero,
  output logic                pendAboveOne,
  output logic                ackFlag,
  output logic                irqOut,
  output logic [PERIOD_W-1:0] effPeriod,
  output logic [CNT_W-1:0]    pendCnt
);
  localparam logic [CNT_W-1:0]    PEND_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]    PEND_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [PERIOD_W-1:0] FLOOR    = PERIOD_W'(MIN_PERIOD);

  logic [CNT_W-1:0]    pendMid;
  logic [CNT_W-1:0]    pendNext;
  logic [PERIOD_W-1:0] clampedPeriod;

  assign pendNonZero  = (pendCnt != '0);
  assign pendAboveOne = (pendCnt > PEND_ONE);

  always_comb begin
    pendMid  = strobe.decPend ? pendCnt - PEND_ONE : pendCnt;
    pendNext = (strobe.incPend && (pendMid != PEND_MAX)) ? pendMid + PEND_ONE : pendMid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCnt <= '0;
      ackFlag <= 1'b1;
      irqOut  <= 1'b0;
    end else begin
      irqOut <= strobe.deliver;
      if (strobe.clrState) begin
        pendCnt <= '0;
        ackFlag <= 1'b1;
      end else begin
        pendCnt <= pendNext;
        ackFlag <= (ackFlag | strobe.ackSet) & ~strobe.deliver;
      end
    end
  end

  generate
    if (MIN_PERIOD > 0) begin : g_clamp
      assign clampedPeriod = (reqPeriod < FLOOR) ? FLOOR : reqPeriod;
    end else begin : g_pass
      assign clampedPeriod = reqPeriod;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            effPeriod <= FLOOR;
    else if (reprogramIn) effPeriod <= clampedPeriod;
  end
endmodule

// File: rtl/tick_reinject.sv
module tick_reinject
  import tick_reinject_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int PERIOD_W   = 16,
  parameter int MIN_PERIOD = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickIn,
  input  logic                ackIn,
  input  logic                unmaskIn,
  input  logic                reinjectEn,
  input  logic                reprogramIn,
  input  logic [PERIOD_W-1:0] reqPeriod,
  output logic                irqOut,
  output logic [PERIOD_W-1:0] effPeriod
);
  ctrlStrobe_t      strobe;
  logic             pendNonZero;
  logic             pendAboveOne;
  logic             ackFlag;
  logic [CNT_W-1:0] pendCnt;

  tick_reinject_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .ackIn(ackIn),
    .unmaskIn(unmaskIn), .reinjectEn(reinjectEn), .reprogramIn(reprogramIn),
    .pendNonZero(pendNonZero), .pendAboveOne(pendAboveOne),
    .ackFlag(ackFlag), .strobe(strobe)
  );

  tick_reinject_dp #(
    .CNT_W(CNT_W), .PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reprogramIn(reprogramIn),
    .reqPeriod(reqPeriod), .pendNonZero(pendNonZero),
    .pendAboveOne(pendAboveOne), .ackFlag(ackFlag), .irqOut(irqOut),
    .effPeriod(effPeriod), .pendCnt(pendCnt)
  );
endmodule

// File: rtl/tick_reinject_chk.sv
module tick_reinject_chk #(
  parameter int CNT_W      = 4,
  parameter int PERIOD_W   = 16,
  parameter int MIN_PERIOD = 100
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickIn,
  input logic                ackIn,
  input logic                unmaskIn,
  input logic                reinjectEn,
  input logic                reprogramIn,
  input logic                irqOut,
  input logic [PERIOD_W-1:0] effPeriod,
  input logic                ackFlag,
  input logic [CNT_W-1:0]    pendCnt
);
  localparam logic [CNT_W-1:0] PEND_MAX = {CNT_W{1'b1}};

  assert_disabled_forward_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!reinjectEn && tickIn) |=> irqOut);

  assert_clear_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reinjectEn && (reprogramIn || unmaskIn)) |=> (pendCnt == '0 && ackFlag && !irqOut));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reinjectEn && pendCnt == PEND_MAX && tickIn && !ackIn && !reprogramIn && !unmaskIn)
    |=> pendCnt == PEND_MAX);

  assert_gated_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reinjectEn && !ackFlag && tickIn && !ackIn) |=> !irqOut);

  assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(tickIn || (ackIn && reinjectEn)));

  assert_clamp_floor_R9: assert property (@(posedge clk) disable iff (!rstN)
    reprogramIn |=> effPeriod >= PERIOD_W'(MIN_PERIOD));
endmodule

bind tick_reinject tick_reinject_chk #(
  .CNT_W(CNT_W), .PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)
) u_chk (
  .clk(clk), .rstN(rstN), .tickIn(tickIn), .ackIn(ackIn),
  .unmaskIn(unmaskIn), .reinjectEn(reinjectEn), .reprogramIn(reprogramIn),
  .irqOut(irqOut), .effPeriod(effPeriod), .ackFlag(ackFlag), .pendCnt(pendCnt)
);

// File: tb/tick_reinject_bench.sv
module tick_reinject_bench;
  localparam int CNT_W      = 4;
  localparam int PERIOD_W   = 16;
  localparam int MIN_PERIOD = 100;
  localparam int SAT_PULSES = (2 ** CNT_W) - 2;
  localparam int NVEC       = 24;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                tickIn = 1'b0;
  logic                ackIn = 1'b0;
  logic                unmaskIn = 1'b0;
  logic                reinjectEn = 1'b1;
  logic                reprogramIn = 1'b0;
  logic [PERIOD_W-1:0] reqPeriod = '0;
  logic                irqOut;
  logic [PERIOD_W-1:0] effPeriod;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_reinject #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_tick_reinject (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .ackIn(ackIn), .unmaskIn(unmaskIn),
    .reinjectEn(reinjectEn), .reprogramIn(reprogramIn), .reqPeriod(reqPeriod),
    .irqOut(irqOut), .effPeriod(effPeriod)
  );

  // {reqTag[3:0], en, tick, ack, unmask, reprog, expectedIrq}
  localparam logic [9:0] VEC [NVEC] = '{
    {4'd2, 6'b110001},  // R2 tick, flag set -> pulse
    {4'd2, 6'b100000},  // R2 idle -> low again
    {4'd3, 6'b110000},  // R3 tick gated, backlog 2
    {4'd3, 6'b110000},  // R3 tick gated, backlog 3
    {4'd4, 6'b101001},  // R4 ack, backlog 2 -> pulse
    {4'd4, 6'b101001},  // R4 ack, backlog 1 -> pulse
    {4'd4, 6'b101000},  // R4 ack, backlog 0 -> none
    {4'd4, 6'b101000},  // R4 ack on empty -> none
    {4'd2, 6'b110001},  // R2 tick -> pulse, backlog 1
    {4'd5, 6'b111001},  // R5 ack then tick -> one pulse
    {4'd3, 6'b110000},  // R3 gated, backlog 2
    {4'd5, 6'b111001},  // R5 ack(2->1 req) then tick -> one pulse
    {4'd7, 6'b100010},  // R7 reprogram clears
    {4'd7, 6'b110001},  // R7 flag restored -> pulse
    {4'd3, 6'b110000},  // R3 gated
    {4'd7, 6'b100100},  // R7 unmask clears
    {4'd7, 6'b110100},  // R7 tick with unmask discarded
    {4'd7, 6'b110001},  // R7 flag set -> pulse
    {4'd8, 6'b010001},  // R8 disabled tick -> pulse
    {4'd8, 6'b001000},  // R8 disabled ack -> none
    {4'd8, 6'b010001},  // R8 disabled tick -> pulse
    {4'd7, 6'b100000},  // R7 enable rise clears
    {4'd7, 6'b110001},  // R7 flag restored by enable rise -> pulse
    {4'd4, 6'b101000}   // R4 ack, backlog 1 -> 0, none
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic tk, input logic ak,
                      input logic um, input logic rp);
    reinjectEn = en; tickIn = tk; ackIn = ak; unmaskIn = um; reprogramIn = rp;
    @(posedge clk);
    @(negedge clk);
    tickIn = 1'b0; ackIn = 1'b0; unmaskIn = 1'b0; reprogramIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1 irqOut after reset", 32'(irqOut), 0);
    check("R1 effPeriod after reset", 32'(effPeriod), MIN_PERIOD);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      check($sformatf("R%0d vector %0d", VEC[i][9:6], i), 32'(irqOut), 32'(VEC[i][0]));
    end

    // R9 clamp
    reqPeriod = 16'd5;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 small request clamped", 32'(effPeriod), MIN_PERIOD);
    reqPeriod = 16'd300;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 large request kept", 32'(effPeriod), 300);
    reqPeriod = 16'(MIN_PERIOD);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 request at floor", 32'(effPeriod), MIN_PERIOD);

    // R6 saturation: fill far past capacity, then drain with acks
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 first tick delivered", 32'(irqOut), 1);
    for (int i = 0; i < 19; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      if (irqOut) pulses++;
    end
    check("R6 pulses released from saturated backlog", 32'(pulses), SAT_PULSES);

    // R8 ack while disabled leaves flag clear; R7 enable rise restores it
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 tick after drain", 32'(irqOut), 1);
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 disabled ack no pulse", 32'(irqOut), 0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 tick after enable rise", 32'(irqOut), 1);

    // R1 reset in mid-operation
    tickIn = 1'b1;
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    tickIn = 1'b0;
    check("R1 irqOut held low in reset", 32'(irqOut), 0);
    rstN = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R1 first tick after reset delivered", 32'(irqOut), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule